// File: doc/BRIEF.md
# VPD Capability Register Pair with EEPROM Byte Sequencer

This block provides the Vital Product Data capability of a bridge's configuration space. It consists of two dwords. The first dword is a header that holds a fixed capability ID, a fixed link to the next capability, a dword address and an operation flag. The second dword holds 32 bits of product data. Software places a dword address in the header and writes the flag. The flag's value selects the operation: 0 fetches four bytes from a serial EEPROM into the data dword, and 1 stores the data dword into the EEPROM.

The EEPROM side is a simple byte port with a request/acknowledge handshake. Each operation moves four bytes, lowest byte first. Every byte address is shifted up by a fixed 0x40, so the product data sits above the first 64 bytes of the device. Software learns that an operation has finished when the flag inverts. A fetch is complete when the flag reads 1. A store is complete when the flag reads 0. Config reads return their data one cycle after the read strobe.

Top module: `vpd_cap`

## Requirements
- R1: The header dword (dword index 0x36, byte offset D8h) reads 03h in bits [7:0] and F0h in bits [15:8]. Bits [30:24] and [17:16] always read 0, and writes do not change any of these bits. A read of any dword index other than 0x36 and 0x37 returns 0. Read data appears on the clock edge that samples `cfg_rd`.
- R2: After reset the header reads 0000F003h and the data dword (index 0x37, byte offset DCh) reads 0.
- R3: A header write with byte enable 2 set loads the 6-bit dword address from bits [23:18], provided no operation is in progress. The address reads back in the same bits. A header write with byte enable 3 clear starts no EEPROM traffic.
- R4: A header write with byte enable 3 set and bit 31 = 0 starts a fetch. Bit 31 reads 0 while the fetch runs and becomes 1 when it ends. The data dword then holds EEPROM bytes k = 0..3 in bits [8k+7:8k].
- R5: A header write with byte enable 3 set and bit 31 = 1 starts a store. Bit 31 reads 1 while the store runs and becomes 0 when it ends. EEPROM byte k then holds data bits [8k+7:8k].
- R6: An operation on dword address A touches EEPROM byte addresses 0x40 + 4A + k, in the order k = 0, 1, 2, 3, and touches no other address.
- R7: Once `ee_req` is raised, it stays high, and `ee_addr`, `ee_we` and `ee_wdata` stay unchanged, until a cycle with `ee_ack` high. The sequencer moves to the next byte only on such a cycle.
- R8: Writes to the data dword update only the bytes whose `cfg_be` bit is set.
- R9: While an operation is in progress, header writes are ignored: no new operation starts and the address does not change. The address and data are captured when the operation starts, so a data-dword write during a store does not change the bytes stored.
- R10: A fetch updates all four data bytes on a single clock edge. Until that edge the data dword keeps its earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dw_addr | input | 6 | Config dword index (byte offset / 4) |
| cfg_wr | input | 1 | Config write strobe |
| cfg_rd | input | 1 | Config read strobe |
| cfg_be | input | 4 | Config write byte enables |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Config read data, registered |
| ee_req | output | 1 | EEPROM byte request |
| ee_we | output | 1 | EEPROM byte direction, 1 = write |
| ee_addr | output | 9 | EEPROM byte address |
| ee_wdata | output | 8 | EEPROM write byte |
| ee_rdata | input | 8 | EEPROM read byte, valid with ee_ack |
| ee_ack | input | 1 | EEPROM byte acknowledge |

## Verification
The hardest states to reach from the ports are those in which config traffic meets an operation still in flight. Examples are a header rewrite, a data-dword overwrite, or a data read that lands between the first and the last byte acknowledge. The bench reaches them by issuing config writes and reads back to back, on the cycles right after the start. The EEPROM responder holds each acknowledge back for zero to three cycles, varied with the address. As a result, these accesses land while the operation is still in progress for every acknowledge latency, across all 64 dword addresses in both directions.

// File: rtl/vpd_pkg.sv
package vpd_pkg;
  localparam int unsigned VPD_BYTES    = 4;
  localparam int unsigned VPD_DWORD_W  = 8 * VPD_BYTES;
  localparam int unsigned VPD_ADDR_LSB = 18;
  localparam int unsigned VPD_FLAG_BIT = 31;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_XFER = 1'b1
  } seq_state_e;

  typedef logic [VPD_DWORD_W-1:0] vpd_dword_t;
endpackage

// File: rtl/vpd_ee_seq.sv
module vpd_ee_seq
  import vpd_pkg::*;
#(
  parameter int unsigned DW_W    = 6,
  parameter int unsigned EE_AW   = 9,
  parameter int unsigned EE_BASE = 'h40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_we,
  input  logic [DW_W-1:0]  start_dw,
  input  vpd_dword_t       start_data,
  output logic             busy,
  output logic             done,
  output vpd_dword_t       done_data,
  output logic             ee_req,
  output logic             ee_we,
  output logic [EE_AW-1:0] ee_addr,
  output logic [7:0]       ee_wdata,
  input  logic [7:0]       ee_rdata,
  input  logic             ee_ack
);
  localparam int unsigned IDX_W = $clog2(VPD_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(VPD_BYTES - 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             we_q;
  logic [DW_W-1:0]  dw_q;
  vpd_dword_t       buf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      we_q    <= 1'b0;
      dw_q    <= '0;
      buf_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q <= SEQ_XFER;
            idx_q   <= '0;
            we_q    <= start_we;
            dw_q    <= start_dw;
            buf_q   <= start_data;
          end
        end
        SEQ_XFER: begin
          if (ee_ack) begin
            if (!we_q) buf_q[8*idx_q +: 8] <= ee_rdata;
            if (idx_q == LAST_IDX) state_q <= SEQ_IDLE;
            else idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign ee_req   = (state_q == SEQ_XFER);
  assign busy     = ee_req;
  assign ee_we    = we_q;
  assign ee_wdata = buf_q[8*idx_q +: 8];
  assign ee_addr  = EE_AW'(EE_BASE) + EE_AW'({dw_q, idx_q});
  assign done     = ee_req && ee_ack && (idx_q == LAST_IDX);

  always_comb begin
    done_data = buf_q;
    done_data[8*(VPD_BYTES-1) +: 8] = ee_rdata;
  end
endmodule

// File: rtl/vpd_cfg_regs.sv
module vpd_cfg_regs
  import vpd_pkg::*;
#(
  parameter int unsigned CFG_DW_AW = 6,
  parameter int unsigned CAP_OFF   = 'hD8,
  parameter int unsigned CAP_ID    = 'h03,
  parameter int unsigned NEXT_PTR  = 'hF0,
  parameter int unsigned DW_W      = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CFG_DW_AW-1:0] cfg_dw_addr,
  input  logic                 cfg_wr,
  input  logic                 cfg_rd,
  input  logic [3:0]           cfg_be,
  input  vpd_dword_t           cfg_wdata,
  output vpd_dword_t           cfg_rdata,
  input  logic                 busy,
  input  logic                 done,
  input  vpd_dword_t           done_data,
  output logic                 start,
  output logic                 start_we,
  output logic [DW_W-1:0]      start_dw,
  output vpd_dword_t           start_data
);
  localparam logic [CFG_DW_AW-1:0] HDR_SEL  = CFG_DW_AW'(CAP_OFF >> 2);
  localparam logic [CFG_DW_AW-1:0] DATA_SEL = CFG_DW_AW'((CAP_OFF >> 2) + 1);

  logic            hit_hdr, hit_data, wr_hdr, wr_data;
  logic [DW_W-1:0] addr_q;
  logic            flag_q;
  vpd_dword_t      data_q;
  vpd_dword_t      hdr_word, rd_mux;

  assign hit_hdr  = (cfg_dw_addr == HDR_SEL);
  assign hit_data = (cfg_dw_addr == DATA_SEL);
  assign wr_hdr   = cfg_wr && hit_hdr;
  assign wr_data  = cfg_wr && hit_data;

  assign start      = wr_hdr && cfg_be[3] && !busy;
  assign start_we   = cfg_wdata[VPD_FLAG_BIT];
  assign start_dw   = cfg_be[2] ? cfg_wdata[VPD_ADDR_LSB +: DW_W] : addr_q;
  assign start_data = data_q;

  always_comb begin
    hdr_word = '0;
    hdr_word[7:0]                     = 8'(CAP_ID);
    hdr_word[15:8]                    = 8'(NEXT_PTR);
    hdr_word[VPD_ADDR_LSB +: DW_W]    = addr_q;
    hdr_word[VPD_FLAG_BIT]            = flag_q;
    if (hit_hdr)       rd_mux = hdr_word;
    else if (hit_data) rd_mux = data_q;
    else               rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      flag_q    <= 1'b0;
      data_q    <= '0;
      cfg_rdata <= '0;
    end else begin
      if (wr_hdr && cfg_be[2] && !busy)
        addr_q <= cfg_wdata[VPD_ADDR_LSB +: DW_W];

      if (start)     flag_q <= cfg_wdata[VPD_FLAG_BIT];
      else if (done) flag_q <= ~flag_q;

      if (done && !flag_q) begin
        data_q <= done_data;
      end else if (wr_data) begin
        for (int b = 0; b < VPD_BYTES; b++)
          if (cfg_be[b]) data_q[8*b +: 8] <= cfg_wdata[8*b +: 8];
      end

      if (cfg_rd) cfg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/vpd_cap.sv
module vpd_cap
  import vpd_pkg::*;
#(
  parameter int unsigned CFG_DW_AW = 6,
  parameter int unsigned CAP_OFF   = 'hD8,
  parameter int unsigned CAP_ID    = 'h03,
  parameter int unsigned NEXT_PTR  = 'hF0,
  parameter int unsigned DW_W      = 6,
  parameter int unsigned EE_AW     = 9,
  parameter int unsigned EE_BASE   = 'h40
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CFG_DW_AW-1:0] cfg_dw_addr,
  input  logic                 cfg_wr,
  input  logic                 cfg_rd,
  input  logic [3:0]           cfg_be,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  output logic                 ee_req,
  output logic                 ee_we,
  output logic [EE_AW-1:0]     ee_addr,
  output logic [7:0]           ee_wdata,
  input  logic [7:0]           ee_rdata,
  input  logic                 ee_ack
);
  logic            seq_start, seq_start_we, seq_busy, seq_done;
  logic [DW_W-1:0] seq_start_dw;
  vpd_dword_t      seq_start_data, seq_done_data;

  vpd_cfg_regs #(
    .CFG_DW_AW(CFG_DW_AW), .CAP_OFF(CAP_OFF), .CAP_ID(CAP_ID),
    .NEXT_PTR(NEXT_PTR), .DW_W(DW_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .cfg_dw_addr(cfg_dw_addr), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .busy(seq_busy), .done(seq_done), .done_data(seq_done_data),
    .start(seq_start), .start_we(seq_start_we), .start_dw(seq_start_dw),
    .start_data(seq_start_data)
  );

  vpd_ee_seq #(
    .DW_W(DW_W), .EE_AW(EE_AW), .EE_BASE(EE_BASE)
  ) u_seq (
    .clk(clk), .rst(rst),
    .start(seq_start), .start_we(seq_start_we), .start_dw(seq_start_dw),
    .start_data(seq_start_data),
    .busy(seq_busy), .done(seq_done), .done_data(seq_done_data),
    .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr),
    .ee_wdata(ee_wdata), .ee_rdata(ee_rdata), .ee_ack(ee_ack)
  );
endmodule

// File: rtl/vpd_cap_chk.sv
module vpd_cap_chk #(
  parameter int unsigned CFG_DW_AW = 6,
  parameter int unsigned CAP_OFF   = 'hD8,
  parameter int unsigned CAP_ID    = 'h03,
  parameter int unsigned NEXT_PTR  = 'hF0,
  parameter int unsigned DW_W      = 6,
  parameter int unsigned EE_AW     = 9,
  parameter int unsigned EE_BASE   = 'h40
) (
  input logic                 clk,
  input logic                 rst,
  input logic [CFG_DW_AW-1:0] cfg_dw_addr,
  input logic                 cfg_wr,
  input logic                 cfg_rd,
  input logic [3:0]           cfg_be,
  input logic [31:0]          cfg_wdata,
  input logic [31:0]          cfg_rdata,
  input logic                 ee_req,
  input logic                 ee_we,
  input logic [EE_AW-1:0]     ee_addr,
  input logic [7:0]           ee_wdata,
  input logic [7:0]           ee_rdata,
  input logic                 ee_ack
);
  localparam logic [CFG_DW_AW-1:0] HDR_SEL = CFG_DW_AW'(CAP_OFF >> 2);
  localparam int unsigned EE_TOP = EE_BASE + 4 * (2 ** DW_W);

  logic rd_hdr_q;
  always_ff @(posedge clk) begin
    if (rst) rd_hdr_q <= 1'b0;
    else     rd_hdr_q <= cfg_rd && (cfg_dw_addr == HDR_SEL);
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    ee_req && !ee_ack |=> ee_req && $stable(ee_addr) && $stable(ee_we) && $stable(ee_wdata)); // R7

  AST_EE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    ee_req |-> (32'(ee_addr) >= EE_BASE) && (32'(ee_addr) < EE_TOP)); // R6

  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (rst)
    ee_req && ee_ack && (ee_addr[1:0] != 2'd3) |=> ee_req && (ee_addr == $past(ee_addr) + 1'b1) && $stable(ee_we)); // R6

  AST_HDR_CONST: assert property (@(posedge clk) disable iff (rst)
    rd_hdr_q |-> cfg_rdata[15:0] == {8'(NEXT_PTR), 8'(CAP_ID)}); // R1

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_hdr_q |-> (cfg_rdata[30:24] == 7'd0) && (cfg_rdata[17:16] == 2'd0)); // R1

  logic unused_chk;
  assign unused_chk = ^{cfg_wr, cfg_be, cfg_wdata, ee_rdata};
endmodule

bind vpd_cap vpd_cap_chk #(
  .CFG_DW_AW(CFG_DW_AW), .CAP_OFF(CAP_OFF), .CAP_ID(CAP_ID),
  .NEXT_PTR(NEXT_PTR), .DW_W(DW_W), .EE_AW(EE_AW), .EE_BASE(EE_BASE)
) u_chk (.*);

// File: tb/vpd_cap_tb.sv
`timescale 1ns/1ps
module vpd_cap_tb;
  localparam logic [5:0] HDR  = 6'h36;
  localparam logic [5:0] DATA = 6'h37;
  localparam logic [5:0] OTHER = 6'h38;
  localparam int BASE = 'h40;

  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  cfg_dw_addr;
  logic        cfg_wr, cfg_rd;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        ee_req, ee_we, ee_ack;
  logic [8:0]  ee_addr;
  logic [7:0]  ee_wdata, ee_rdata;

  always #5 clk = ~clk;

  vpd_cap u_dut (
    .clk(clk), .rst(rst), .cfg_dw_addr(cfg_dw_addr), .cfg_wr(cfg_wr),
    .cfg_rd(cfg_rd), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .ee_req(ee_req), .ee_we(ee_we),
    .ee_addr(ee_addr), .ee_wdata(ee_wdata), .ee_rdata(ee_rdata),
    .ee_ack(ee_ack)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // behavioural EEPROM responder
  logic [7:0] mem [0:511];
  int         lat = 0;
  int         cnt = 0;
  int         stab_err = 0;
  logic [8:0] hold_addr;
  int         log_n = 0;
  logic [8:0] log_addr [0:7];
  logic       log_we   [0:7];

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 37 + 11);
    ee_ack = 1'b0;
    ee_rdata = 8'h00;
    hold_addr = '0;
    forever begin
      @(negedge clk);
      if (ee_req) begin
        if (cnt > 0 && ee_addr != hold_addr) stab_err++;
        hold_addr = ee_addr;
        if (cnt >= lat) begin
          ee_ack = 1'b1;
          if (ee_we) mem[ee_addr] = ee_wdata;
          else       ee_rdata = mem[ee_addr];
          if (log_n < 8) begin
            log_addr[log_n] = ee_addr;
            log_we[log_n]   = ee_we;
          end
          log_n++;
          cnt = 0;
        end else begin
          ee_ack = 1'b0;
          cnt++;
        end
      end else begin
        ee_ack = 1'b0;
        cnt = 0;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic cfg_write(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    cfg_dw_addr = a; cfg_wdata = d; cfg_be = be; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'h0;
  endtask

  task automatic cfg_read(input logic [5:0] a, output logic [31:0] d);
    cfg_dw_addr = a; cfg_rd = 1'b1;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic wait_flag(input logic exp, output logic [31:0] v);
    for (int i = 0; i < 200; i++) begin
      cfg_read(HDR, v);
      if (v[31] == exp) break;
    end
  endtask

  function automatic logic [31:0] hdr_val(input logic flag, input logic [5:0] dw);
    return {flag, 7'd0, dw, 2'd0, 8'hF0, 8'h03};
  endfunction

  task automatic check_log(input string req, input int dw, input logic we);
    check({req, " byte count"}, 32'(log_n), 32'd4);
    for (int k = 0; k < 4; k++) begin
      check({req, " byte address"}, 32'(log_addr[k]), 32'(BASE + 4 * dw + k));
      check({req, " byte direction"}, 32'(log_we[k]), 32'(we));
    end
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, wv, exp;
    rst = 1'b1; cfg_dw_addr = '0; cfg_wr = 1'b0; cfg_rd = 1'b0;
    cfg_be = 4'h0; cfg_wdata = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R2 reset values, R1 header constants and unmapped reads
    cfg_read(HDR, v);   check("R2 header reset", v, 32'h0000F003);
    cfg_read(DATA, v);  check("R2 data reset", v, 32'h0);
    cfg_read(OTHER, v); check("R1 unmapped read", v, 32'h0);

    // R3 address load without start; R1 read-only and reserved bits
    log_n = 0;
    cfg_write(HDR, 32'hFFFF_FFFF, 4'b0111);
    repeat (6) @(negedge clk);
    cfg_read(HDR, v);   check("R3 address load / R1 reserved", v, hdr_val(1'b0, 6'h3F));
    check("R3 no traffic without byte 3", 32'(log_n), 32'd0);
    cfg_write(HDR, 32'h0000_0000, 4'b0100);
    cfg_read(HDR, v);   check("R3 address clear", v, hdr_val(1'b0, 6'h00));

    // R8 byte enables
    cfg_write(DATA, 32'hAABBCCDD, 4'b0101);
    cfg_read(DATA, v);  check("R8 bytes 0,2", v, 32'h00BB00DD);
    cfg_write(DATA, 32'h11223344, 4'b1010);
    cfg_read(DATA, v);  check("R8 bytes 1,3", v, 32'h11BB33DD);

    // fetch sweep over all dword addresses
    for (int dw = 0; dw < 64; dw++) begin
      lat = dw % 4;
      cfg_write(DATA, 32'hDEADBEEF, 4'hF);
      log_n = 0;
      cfg_write(HDR, {1'b0, 7'd0, 6'(dw), 18'd0}, 4'b1100);
      cfg_read(HDR, v);  check("R4 flag low while fetching", 32'(v[31]), 32'd0);
      cfg_read(DATA, v); check("R10 data held mid-fetch", v, 32'hDEADBEEF);
      wait_flag(1'b1, v);
      check("R4 flag high after fetch", v, hdr_val(1'b1, 6'(dw)));
      exp = '0;
      for (int k = 0; k < 4; k++) exp[8*k +: 8] = 8'((BASE + 4 * dw + k) * 37 + 11);
      cfg_read(DATA, v); check("R4 fetched data", v, exp);
      check_log("R6 fetch", dw, 1'b0);
    end

    // store sweep with overlapping config traffic
    for (int dw = 0; dw < 64; dw++) begin
      lat = (dw + 1) % 4;
      wv = 32'h9E3779B9 * 32'(dw + 1);
      cfg_write(DATA, wv, 4'hF);
      log_n = 0;
      cfg_write(HDR, {1'b1, 7'd0, 6'(dw), 18'd0}, 4'b1100);
      cfg_write(HDR, {1'b0, 7'd0, 6'(dw) ^ 6'h01, 18'd0}, 4'b1100);
      cfg_write(DATA, ~wv, 4'hF);
      cfg_read(HDR, v);  check("R5 flag high while storing", v, hdr_val(1'b1, 6'(dw)));
      wait_flag(1'b0, v);
      check("R9 header unchanged after store", v, hdr_val(1'b0, 6'(dw)));
      for (int k = 0; k < 4; k++)
        check("R5 stored byte", 32'(mem[BASE + 4 * dw + k]), 32'(wv[8*k +: 8]));
      check_log("R9 R6 store", dw, 1'b1);
      cfg_read(DATA, v); check("R9 data write during store kept", v, ~wv);
    end

    // R5 read back one stored dword
    lat = 2;
    cfg_write(HDR, {1'b0, 7'd0, 6'd5, 18'd0}, 4'b1100);
    wait_flag(1'b1, v);
    cfg_read(DATA, v); check("R5 store then fetch", v, 32'h9E3779B9 * 32'd6);

    check("R7 address stable while waiting", 32'(stab_err), 32'd0);

    summary();
    $finish;
  end
endmodule